// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a free-running time-of-day value for precision time protocol work. It holds a 96-bit accumulator made of 64 bits of whole nanoseconds above a 32-bit binary fraction. On every core clock cycle while the counter runs, a programmable step is added to the accumulator. The step is a 32.32 fixed-point count of nanoseconds per core cycle. Because the step has a fractional part, software can trim the nominal rate very finely rather than counting whole ticks. The nominal step is (10^9 << 32) divided by the core clock frequency in Hz. At 50 MHz this gives exactly 20 ns, which is 64'h0000_0014_0000_0000.

Software reaches the block through a single-cycle register port. Each request carries a valid flag, a write flag, a 12-bit offset and 64-bit write data. Read data comes back one cycle later with a response-valid flag. Through this port software can:
- enable or stop the counter,
- program the step,
- read the whole-nanosecond time word,
- read the fraction word.

Top module: `tod_counter`

## Requirements
- R1: After reset, all four mapped registers read as zero: the control register, the fraction word, the nanosecond word and the step register.
- R2: The control register at offset 0xF00 holds the run enable in bit 0 and reads back as {63'b0, enable}. Bits 63:1 of write data are ignored. The enable written at a clock edge governs additions from the following edge onward.
- R3: While enabled, the step is added to the 96-bit accumulator at every core clock edge. A read of offset 0xF10 returns accumulator bits 95:32, the whole nanoseconds.
- R4: The fraction carries into the nanosecond part without loss. A read of offset 0xF08 returns accumulator bits 31:0 in data bits 31:0, with bits 63:32 zero.
- R5: The step register at offset 0xF18 holds all 64 written bits and reads them back. The edge that writes a new step still adds the old step, and the new step is used from the next edge. The time does not jump at the change.
- R6: While the enable is clear, the accumulator holds its value.
- R7: A read request sampled at an edge returns, one cycle later with rsp_valid high, the register value as it stood just before that edge. rsp_valid is high only in the cycle after a read request.
- R8: Unmapped offsets read as zero and ignore writes. The 0xF08 and 0xF10 time words are read-only, and writes to them leave the time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the accumulator advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register offset |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data |

## Verification
A wrong accumulator or step value shows at the ports only when software reads a time word. From then on the error persists as a fixed or growing offset from the expected time: each enabled cycle adds to the distance, and nothing ever removes it. An enable taking effect one edge early or late, or a step change applied on the wrong edge, leaves an offset of exactly one step. The bench therefore freezes the counter and compares full 96-bit readings against an expected count of additions. A wrong read multiplexer or missed snapshot timing shows on the very next response, so every read response is compared against a cycle-exact reference.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_FRAC = 12'hF08;
    localparam logic [ADDR_W-1:0] OFS_NS   = 12'hF10;
    localparam logic [ADDR_W-1:0] OFS_STEP = 12'hF18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_FRAC,
        SEL_NS,
        SEL_STEP
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL: s = SEL_CTRL;
            OFS_FRAC: s = SEL_FRAC;
            OFS_NS:   s = SEL_NS;
            OFS_STEP: s = SEL_STEP;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tod_ctrl_regs.sv
module tod_ctrl_regs
    import tod_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              run_q,
    output logic [STEP_W-1:0] step_q
);

    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
    } regs_t;

    regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_en && sel == SEL_CTRL) nxt_d.run  = wdata[0];
        if (wr_en && sel == SEL_STEP) nxt_d.step = STEP_W'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign run_q  = cur_q.run;
    assign step_q = cur_q.step;

    // R5: a step write is captured whole on the next edge
    assert_step_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STEP) |=> (step_q == $past(STEP_W'(wdata))));

    // R5/R8: the step changes only through its own offset
    assert_step_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_STEP) |=> $stable(step_q));

    // R2: the enable changes only through the control offset
    assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_CTRL) |=> $stable(run_q));

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [STEP_W-1:0] step,
    output logic [NS_W-1:0]   ns_q,
    output logic [FRAC_W-1:0] frac_q
);

    localparam int ACC_W = NS_W + FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (run) nxt_d.acc = cur_q.acc + ACC_W'(step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ns_q   = cur_q.acc[ACC_W-1:FRAC_W];
    assign frac_q = cur_q.acc[FRAC_W-1:0];

    // R6: a stopped counter keeps its time
    assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(ns_q) && $stable(frac_q)));

    // R3: a running counter with a nonzero step moves every edge
    assert_moves_when_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step != '0) |=> !($stable(ns_q) && $stable(frac_q)));

endmodule

// File: rtl/tod_read_port.sv
module tod_read_port
    import tod_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic              run,
    input  logic [FRAC_W-1:0] frac,
    input  logic [NS_W-1:0]   ns,
    input  logic [STEP_W-1:0] step,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t cur_q, nxt_d;
    logic [DATA_W-1:0] mux_val;

    always_comb begin
        case (sel)
            SEL_CTRL: mux_val = DATA_W'(run);
            SEL_FRAC: mux_val = DATA_W'(frac);
            SEL_NS:   mux_val = DATA_W'(ns);
            SEL_STEP: mux_val = DATA_W'(step);
            default:  mux_val = '0;
        endcase
    end

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = rd_en;
        if (rd_en) nxt_d.rdata = mux_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rsp_valid = cur_q.valid;
    assign rsp_rdata = cur_q.rdata;

    // R7: the nanosecond word is the value held at the request edge
    assert_ns_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NS) |=> (rsp_rdata == $past(DATA_W'(ns))));

    // R8: unmapped offsets read back as zero
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rsp_rdata == '0));

    // R7: a response appears exactly one cycle after each read
    assert_rsp_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid);

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int STEP_W = 32 + FRAC_W;

    reg_sel_e          sel;
    logic              wr_en;
    logic              rd_en;
    logic              run_q;
    logic [STEP_W-1:0] step_q;
    logic [NS_W-1:0]   ns_q;
    logic [FRAC_W-1:0] frac_q;

    assign sel   = decode_sel(req_addr);
    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;

    tod_ctrl_regs #(
        .DATA_W (DATA_W),
        .STEP_W (STEP_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (req_wdata),
        .run_q  (run_q),
        .step_q (step_q)
    );

    tod_accum #(
        .NS_W   (NS_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .step   (step_q),
        .ns_q   (ns_q),
        .frac_q (frac_q)
    );

    tod_read_port #(
        .DATA_W (DATA_W),
        .NS_W   (NS_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .sel       (sel),
        .run       (run_q),
        .frac      (frac_q),
        .ns        (ns_q),
        .step      (step_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
module sim_tod_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tod_counter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model of the register map, advanced at each edge
    logic [95:0] acc_m;
    logic [63:0] step_m;
    logic        run_m;
    logic        exp_rv;
    logic [63:0] exp_rd;
    logic [11:0] exp_addr;

    function automatic logic [63:0] model_read(input logic [11:0] a, input logic [95:0] acc,
                                               input logic [63:0] st, input logic en);
        case (a)
            12'hF00: return {63'b0, en};
            12'hF08: return {32'b0, acc[31:0]};
            12'hF10: return acc[95:32];
            12'hF18: return st;
            default: return 64'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] a);
        case (a)
            12'hF00: return "R2";
            12'hF08: return "R4";
            12'hF10: return "R3";
            12'hF18: return "R5";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_m <= '0; step_m <= '0; run_m <= 1'b0;
            exp_rv <= 1'b0; exp_rd <= '0; exp_addr <= '0;
        end else begin
            if (run_m) acc_m <= acc_m + {32'b0, step_m};
            if (req_valid && req_write) begin
                if (req_addr == 12'hF00) run_m <= req_wdata[0];
                if (req_addr == 12'hF18) step_m <= req_wdata;
            end
            exp_rv <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                exp_rd   <= model_read(req_addr, acc_m, step_m, run_m);
                exp_addr <= req_addr;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 rsp_valid", {63'b0, rsp_valid}, {63'b0, exp_rv});
            if (exp_rv) chk(req_of(exp_addr), rsp_rdata, exp_rd);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic read_time(output logic [95:0] t);
        logic [63:0] hi, lo;
        rd(12'hF10, hi);
        rd(12'hF08, lo);
        t = {hi, lo[31:0]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [95:0] t0, t1;
        logic [63:0] step_a, step_b;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(12'hF00, d); chk("R1 ctrl", d, 64'h0);
        rd(12'hF08, d); chk("R1 frac", d, 64'h0);
        rd(12'hF10, d); chk("R1 ns", d, 64'h0);
        rd(12'hF18, d); chk("R1 step", d, 64'h0);

        // R5: step readback; R6: stopped counter stays at zero
        step_a = 64'h0000_0014_0000_0000;
        wr(12'hF18, step_a);
        rd(12'hF18, d); chk("R5 step readback", d, step_a);
        repeat (5) @(negedge clk);
        rd(12'hF10, d); chk("R6 ns while stopped", d, 64'h0);

        // R2: only bit 0 of control is kept
        wr(12'hF00, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'hF00, d); chk("R2 enable readback", d, 64'h1);
        wr(12'hF00, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(12'hF00, d); chk("R2 enable cleared", d, 64'h0);

        // R8: unmapped and read-only offsets
        read_time(t0);
        wr(12'h010, 64'hDEAD_BEEF_0000_0001);
        wr(12'hF10, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'hF08, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h010, d); chk("R8 unmapped reads zero", d, 64'h0);
        read_time(t1); chk("R8 time ns unchanged", t1[95:32], t0[95:32]);
        chk("R8 time frac unchanged", {32'b0, t1[31:0]}, {32'b0, t0[31:0]});
        rd(12'hF18, d); chk("R8 step unchanged", d, step_a);
        rd(12'hF00, d); chk("R8 ctrl unchanged", d, 64'h0);

        // R4: fractional step, 10 additions of 0.75 ns
        wr(12'hF18, 64'h0000_0000_C000_0000);
        read_time(t0);
        wr(12'hF00, 64'h1);
        repeat (9) @(negedge clk);
        wr(12'hF00, 64'h0);
        read_time(t1);
        t0 = t0 + 96'h0000_0000_C000_0000 * 96'd10;
        chk("R4 ns after carries", t1[95:32], t0[95:32]);
        chk("R4 frac after carries", {32'b0, t1[31:0]}, {32'b0, t0[31:0]});

        // R5: step change mid-run, 6 adds of A then 4 adds of B
        step_a = 64'h0000_0014_0000_0000;
        step_b = 64'h0000_0001_8000_0000;
        wr(12'hF18, step_a);
        read_time(t0);
        wr(12'hF00, 64'h1);
        repeat (5) @(negedge clk);
        wr(12'hF18, step_b);
        repeat (3) @(negedge clk);
        wr(12'hF00, 64'h0);
        read_time(t1);
        t0 = t0 + {32'b0, step_a} * 96'd6 + {32'b0, step_b} * 96'd4;
        chk("R5 ns across step change", t1[95:32], t0[95:32]);
        chk("R5 frac across step change", {32'b0, t1[31:0]}, {32'b0, t0[31:0]});

        // R3/R7: random traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [11:0] a;
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1:    a = 12'hF10;
                2:       a = 12'hF08;
                3:       a = 12'hF00;
                4:       a = 12'hF18;
                5:       a = 12'($urandom);
                default: a = 12'hF10;
            endcase
            req_addr  = a;
            req_write = ($urandom_range(0, 3) == 0);
            req_valid = ($urandom_range(0, 3) != 0);
            if (a == 12'hF00)
                req_wdata = {$urandom, $urandom} | 64'h1;
            else
                req_wdata = {16'b0, 16'($urandom), $urandom};
            if (req_write && $urandom_range(0, 7) == 0 && a == 12'hF00)
                req_wdata[0] = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);

        // R3: directed running read of the nanosecond word
        rd(12'hF10, d);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule